// File: doc/BRIEF.md
# Front-Panel Clock and Display Controller

This controller sits between a slow educational processor and a small hands-on front panel made of three rows of eight LEDs and a five-way joystick. It divides the fast board clock into a one-cycle CPU clock-enable pulse. The pulse comes at one of six step rates, from a halt-free stop up to about 2 kHz. Pressing Set pauses and resumes the processor. When the rate is zero, each Set press instead advances the processor by exactly one step.

The joystick's horizontal axis changes the step rate. Its vertical axis chooses which of the eight processor registers is shown. Both axes repeat automatically while a button is held. The status row shows the four arithmetic flags, the selected register number and a clock indicator. The indicator glows faintly in the phase after each step and turns fully on when the processor reports halt. The second row shows the selected register and the third row shows the program counter. The joystick lines arrive already debounced.

Timing is built on a base tick of `TICK_CYCLES` board clocks, which is 0.5 ms by default. The rate periods and the hold and repeat delays are all counted in ticks.

Top module: `fp_panel_ctrl`

## Requirements
- R1: Reset (synchronous, active high) sets the step rate to level `INIT_LEVEL` (default 2), selects register 0, clears the pause state and darkens the clock indicator phase.
- R2: A running processor gets one single-cycle `cpu_en` pulse every P ticks. P is 8333, 2000, 500, 133 or 1 for levels 1 to 5.
- R3: Right raises the level and Left lowers it. The level holds at 5 and at 0. Pressing both buttons at once leaves it unchanged.
- R4: Up raises the register index and Down lowers it, wrapping modulo 8. Pressing both at once leaves it unchanged.
- R5: A held Left, Right, Up or Down button acts once when pressed, again after `HOLD_TICKS` ticks (default 1000), and then every `REP_TICKS` ticks (default 300).
- R6: At levels 1 to 5, each rising edge of Set toggles the pause state. While paused, no `cpu_en` pulse is produced.
- R7: At level 0, `cpu_en` pulses exactly once per rising edge of Set, however long the button is held, and never otherwise.
- R8: `led_status[7:4]` shows C, Z, S, V, taken from `cpu_flags[4:1]`, and `led_status[3:1]` shows the register index. `led_data` shows byte `idx` of `reg_file` (bits `8*idx+7 : 8*idx`), and `led_pc` shows `pc`.
- R9: `led_status[0]` is steadily on while `cpu_flags[0]` (halt) is set. Otherwise it is on in one of every eight board cycles during the phase after an odd number of steps since reset, and off during the other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_left | input | 1 | Lower step rate (debounced) |
| btn_right | input | 1 | Raise step rate (debounced) |
| btn_up | input | 1 | Next register (debounced) |
| btn_down | input | 1 | Previous register (debounced) |
| btn_set | input | 1 | Pause/resume, or single step at level 0 |
| cpu_flags | input | 5 | {C, Z, S, V, H} from the processor |
| reg_file | input | 64 | Eight 8-bit register values, register k at bits 8k+7:8k |
| pc | input | 8 | Processor program counter |
| cpu_en | output | 1 | One-cycle processor clock enable |
| led_status | output | 8 | {C, Z, S, V, index[2:0], clock indicator} |
| led_data | output | 8 | Selected register value |
| led_pc | output | 8 | Program counter value |

## Verification
The step rate is measured by counting `cpu_en` pulses over windows sized against the period tables. A window of a few hundred cycles separates level 5 from every slower level. Longer windows separate levels 2 and 3 from their neighbours and from zero, which shows both the saturation at the two ends and the effect of pausing. Single stepping is checked with repeated short presses and with one long press, which shows that a held Set issues one step and no more. Holds shorter and longer than the repeat delay are applied to the register index, and a long hold is applied to the rate so that the repeats run into the upper limit. The clock indicator is sampled over sixteen-cycle windows before and after a single step, and again with halt raised, to show the difference between dim, dark and solid.

// File: rtl/fp_pkg.sv
package fp_pkg;

    localparam int LEVEL_W   = 3;
    localparam int MAX_LEVEL = 5;
    localparam int PERIOD_W  = 14;
    localparam int NUM_REGS  = 8;
    localparam int REG_W     = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NAV_N     = 4;

    typedef logic [LEVEL_W-1:0]  level_t;
    typedef logic [IDX_W-1:0]    idx_t;
    typedef logic [PERIOD_W-1:0] period_t;

    // Flag bundle from the processor, MSB first: carry .. halt
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic h;
    } flags_t;

    // Position of each navigation button in the button vector
    typedef enum int {
        NAV_LEFT  = 0,
        NAV_RIGHT = 1,
        NAV_UP    = 2,
        NAV_DOWN  = 3
    } nav_e;

    // Step period in base ticks for each rate level (0 means stopped)
    function automatic period_t level_period(level_t lv);
        case (lv)
            3'd1:    return period_t'(8333);
            3'd2:    return period_t'(2000);
            3'd3:    return period_t'(500);
            3'd4:    return period_t'(133);
            3'd5:    return period_t'(1);
            default: return period_t'(0);
        endcase
    endfunction

    // Saturating level update, opposite requests cancel
    function automatic level_t level_next(level_t lv, logic inc, logic dec);
        if (inc && !dec && lv != level_t'(MAX_LEVEL)) return level_t'(lv + 3'd1);
        if (dec && !inc && lv != '0)                   return level_t'(lv - 3'd1);
        return lv;
    endfunction

    // Wrapping index update, opposite requests cancel
    function automatic idx_t idx_next(idx_t ix, logic inc, logic dec);
        if (inc && !dec) return idx_t'(ix + 1'b1);
        if (dec && !inc) return idx_t'(ix - 1'b1);
        return ix;
    endfunction

endpackage

// File: rtl/fp_tick_gen.sv
module fp_tick_gen #(
    parameter int TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [CNT_W-1:0] div_cnt;

    assign tick = (div_cnt == CNT_W'(TICK_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst)       div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/fp_repeat.sv
module fp_repeat #(
    parameter int HOLD_TICKS = 1000,
    parameter int REP_TICKS  = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    input  logic tick,
    output logic fire
);
    localparam int LIM  = (HOLD_TICKS > REP_TICKS) ? HOLD_TICKS : REP_TICKS;
    localparam int CW   = $clog2(LIM + 1);

    logic          btn_q;
    logic          first_wait;
    logic          fire_q;
    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] limit;
    logic          press;
    logic          again;

    assign press = btn & ~btn_q;
    assign limit = first_wait ? CW'(HOLD_TICKS - 1) : CW'(REP_TICKS - 1);
    assign again = btn & btn_q & tick & (hold_cnt == limit);
    assign fire  = fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q      <= 1'b0;
            first_wait <= 1'b1;
            hold_cnt   <= '0;
            fire_q     <= 1'b0;
        end else begin
            btn_q  <= btn;
            fire_q <= press | again;
            if (press) begin
                hold_cnt   <= '0;
                first_wait <= 1'b1;
            end else if (btn && tick) begin
                if (hold_cnt == limit) begin
                    hold_cnt   <= '0;
                    first_wait <= 1'b0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

    // R5
    fire_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/fp_step_gen.sv
module fp_step_gen
    import fp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  level_t level,
    input  logic   set_btn,
    output logic   cpu_en
);
    logic    set_q;
    logic    paused;
    logic    en_q;
    period_t rate_cnt;
    period_t period;
    logic    set_press;
    logic    stopped;
    logic    running;
    logic    due;

    assign period    = level_period(level);
    assign set_press = set_btn & ~set_q;
    assign stopped   = (level == '0);
    assign running   = !stopped && !paused;
    assign due       = running && tick && (rate_cnt >= period - period_t'(1));
    assign cpu_en    = en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q    <= 1'b0;
            paused   <= 1'b0;
            en_q     <= 1'b0;
            rate_cnt <= '0;
        end else begin
            set_q <= set_btn;
            en_q  <= due | (stopped & set_press);
            if (set_press && !stopped) paused <= ~paused;
            if (!running || due) rate_cnt <= '0;
            else if (tick)       rate_cnt <= rate_cnt + 1'b1;
        end
    end

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && $past(stopped)) |-> $past(set_press));

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (paused && !stopped) |=> !cpu_en);
endmodule

// File: rtl/fp_panel_ctrl.sv
module fp_panel_ctrl
    import fp_pkg::*;
#(
    parameter int TICK_CYCLES = 50000,
    parameter int HOLD_TICKS  = 1000,
    parameter int REP_TICKS   = 300,
    parameter int INIT_LEVEL  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      btn_left,
    input  logic                      btn_right,
    input  logic                      btn_up,
    input  logic                      btn_down,
    input  logic                      btn_set,
    input  logic [4:0]                cpu_flags,
    input  logic [NUM_REGS*REG_W-1:0] reg_file,
    input  logic [REG_W-1:0]          pc,
    output logic                      cpu_en,
    output logic [7:0]                led_status,
    output logic [REG_W-1:0]          led_data,
    output logic [REG_W-1:0]          led_pc
);
    logic             tick;
    logic [NAV_N-1:0] nav_raw;
    logic [NAV_N-1:0] nav_fire;
    level_t           level;
    idx_t             idx;
    logic [2:0]       pwm_cnt;
    logic             blink;
    flags_t           fl;
    logic             clk_led;

    assign nav_raw = {btn_down, btn_up, btn_right, btn_left};

    fp_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar b = 0; b < NAV_N; b++) begin : g_nav
        fp_repeat #(.HOLD_TICKS(HOLD_TICKS), .REP_TICKS(REP_TICKS)) u_rep (
            .clk  (clk),
            .rst  (rst),
            .btn  (nav_raw[b]),
            .tick (tick),
            .fire (nav_fire[b])
        );
    end

    fp_step_gen u_step (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .level   (level),
        .set_btn (btn_set),
        .cpu_en  (cpu_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= level_t'(INIT_LEVEL);
            idx     <= '0;
            pwm_cnt <= '0;
            blink   <= 1'b0;
        end else begin
            level   <= level_next(level, nav_fire[NAV_RIGHT], nav_fire[NAV_LEFT]);
            idx     <= idx_next(idx, nav_fire[NAV_UP], nav_fire[NAV_DOWN]);
            pwm_cnt <= pwm_cnt + 1'b1;
            if (cpu_en) blink <= ~blink;
        end
    end

    assign fl         = flags_t'(cpu_flags);
    assign clk_led    = fl.h | (blink & (pwm_cnt == 3'd0));
    assign led_status = {fl.c, fl.z, fl.s, fl.v, idx, clk_led};
    assign led_data   = reg_file[REG_W*int'(idx) +: REG_W];
    assign led_pc     = pc;

    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        level <= level_t'(MAX_LEVEL));

    // R3
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |->
            ((level == $past(level) + 3'd1) || ($past(level) == level + 3'd1)));

    // R9
    dim_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_flags[0] && led_status[0]) |=> (!led_status[0] || cpu_flags[0]));
endmodule

// File: tb/fp_panel_ctrl_bench.sv
module fp_panel_ctrl_bench;
    localparam int TICK = 4;
    localparam int HOLD = 1000;
    localparam int REP  = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  nav = '0;   // {down, up, right, left}
    logic        set_b = 1'b0;
    logic [4:0]  flags = 5'b10100;
    logic [63:0] regs;
    logic [7:0]  pc = 8'h5A;
    logic        cpu_en;
    logic [7:0]  led_status, led_data, led_pc;

    int checks = 0;
    int errors = 0;
    int en_total = 0;

    always #5 clk = ~clk;

    fp_panel_ctrl #(.TICK_CYCLES(TICK), .HOLD_TICKS(HOLD), .REP_TICKS(REP),
                    .INIT_LEVEL(2)) u_fp_panel_ctrl (
        .clk(clk), .rst(rst),
        .btn_left(nav[0]), .btn_right(nav[1]), .btn_up(nav[2]), .btn_down(nav[3]),
        .btn_set(set_b), .cpu_flags(flags), .reg_file(regs), .pc(pc),
        .cpu_en(cpu_en), .led_status(led_status), .led_data(led_data), .led_pc(led_pc)
    );

    function automatic logic [7:0] reg_val(int k);
        return 8'(k * 37 + 27);
    endfunction

    initial for (int k = 0; k < 8; k++) regs[k*8 +: 8] = reg_val(k);

    always @(negedge clk) if (!rst && cpu_en) en_total++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(string req, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic hold_nav(int b, int cycles);
        @(negedge clk) nav[b] = 1'b1;
        repeat (cycles) @(negedge clk);
        nav[b] = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic tap_nav(int b, int times);
        for (int i = 0; i < times; i++) hold_nav(b, 10);
    endtask

    task automatic hold_set(int cycles);
        @(negedge clk) set_b = 1'b1;
        repeat (cycles) @(negedge clk);
        set_b = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic steps_in(int cycles, output int n);
        int s0;
        s0 = en_total;
        repeat (cycles) @(negedge clk);
        n = en_total - s0;
    endtask

    task automatic led_on_count(int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (led_status[0]) n++;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk) rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int n;
        apply_reset();
        check("R1 index after reset", int'(led_status[3:1]), 0);
        check("R8 data row", int'(led_data), int'(reg_val(0)));
        check("R8 pc row", int'(led_pc), 8'h5A);
        check("R8 flag bits", int'(led_status[7:4]), 4'b1010);
        check("R9 indicator dark after reset", int'(led_status[0]), 0);
        steps_in(24000, n);
        check_range("R2 level 2 rate", n, 2, 4);
    endtask

    task automatic t_display();
        flags = 5'b01010;
        pc = 8'hC3;
        @(negedge clk);
        check("R8 flag bits second pattern", int'(led_status[7:4]), 4'b0101);
        check("R8 pc follows", int'(led_pc), 8'hC3);
        tap_nav(2, 3);
        check("R4 up three", int'(led_status[3:1]), 3);
        check("R8 data selected", int'(led_data), int'(reg_val(3)));
        tap_nav(2, 5);
        check("R4 wrap upward", int'(led_status[3:1]), 0);
        tap_nav(3, 1);
        check("R4 wrap downward", int'(led_status[3:1]), 7);
        check("R8 data reg 7", int'(led_data), int'(reg_val(7)));
        @(negedge clk) nav[2] = 1'b1; nav[3] = 1'b1;
        repeat (10) @(negedge clk);
        nav = '0;
        repeat (20) @(negedge clk);
        check("R4 both pressed no change", int'(led_status[3:1]), 7);
        flags = 5'b00000;
    endtask

    task automatic t_speed();
        int n;
        tap_nav(1, 5);
        steps_in(400, n);
        check_range("R3 saturate at 5", n, 99, 101);
        tap_nav(0, 2);
        steps_in(10000, n);
        check_range("R2 level 3 rate", n, 4, 6);
        tap_nav(0, 5);
        steps_in(10000, n);
        check("R3 floor at 0", n, 0);
        tap_nav(1, 2);
        steps_in(24000, n);
        check_range("R3 back to level 2 after floor", n, 2, 4);
        tap_nav(0, 2);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_step();
        int s0;
        s0 = en_total;
        for (int i = 0; i < 3; i++) hold_set(10);
        check("R7 one step per press", en_total - s0, 3);
        s0 = en_total;
        hold_set(3000);
        check("R7 long press single step", en_total - s0, 1);
    endtask

    task automatic t_clock_led();
        int a, b, ok;
        led_on_count(16, a);
        hold_set(10);
        led_on_count(16, b);
        ok = ((a == 0 && b == 2) || (a == 2 && b == 0)) ? 1 : 0;
        check("R9 dim phase toggles per step", ok, 1);
        flags = 5'b00001;
        led_on_count(16, a);
        check("R9 solid on halt", a, 16);
        flags = 5'b00000;
    endtask

    task automatic t_pause();
        int n;
        tap_nav(1, 3);
        hold_set(10);
        steps_in(10000, n);
        check("R6 paused no steps", n, 0);
        hold_set(10);
        steps_in(10000, n);
        check_range("R6 resumed level 3", n, 4, 6);
    endtask

    task automatic t_repeat();
        int n;
        hold_nav(2, HOLD * TICK + (REP * TICK * 5) / 2);
        check("R5 long hold four moves", int'(led_status[3:1]), 3);
        hold_nav(2, HOLD * TICK / 2);
        check("R5 short hold one move", int'(led_status[3:1]), 4);
        hold_nav(1, HOLD * TICK + (REP * TICK * 5) / 2);
        steps_in(400, n);
        check_range("R5 held right reaches level 5", n, 99, 101);
    endtask

    task automatic t_reset_again();
        int n;
        hold_set(10);
        apply_reset();
        check("R1 index cleared", int'(led_status[3:1]), 0);
        steps_in(24000, n);
        check_range("R1 unpaused at init level", n, 2, 4);
    endtask

    initial begin
        t_reset();
        t_display();
        t_speed();
        t_step();
        t_clock_led();
        t_pause();
        t_repeat();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule